// File: doc/BRIEF.md
# System Address Decoder with Top-of-Map Remap

This block sits between the bus masters of a processor subsystem and its memory regions. Each master presents a 24-bit byte address, a master code and a request strobe. The block returns a one-hot select for the region that serves the access and the address as the processor sees it. It also raises an error flag when that master may not use that region. The decode is purely combinational, so the select, the address and the error flag are valid in the same cycle as the request.

Bus-side masters, which are the USB engine and the four DMA engines, see the two internal RAMs through address windows that sit above the processor's view. The block subtracts a fixed offset per window to reach the processor address. The top 128 KB of the map normally reaches internal ROM. A one-bit remap register, loaded through a small write port, hands that range to the highest external chip-select space instead. A hardware reset clears the remap bit. A software reset leaves it as it was.

Top module: `sys_addr_decoder`

## Requirements
- R1: For the processor (master code 0) the map decodes as follows. 000000h–0000BFh is registers (select bit 0). 0000C0h–00FFFFh is dual-access RAM (bit 1). 010000h–04FFFFh is single-access RAM (bit 2). 050000h–7FFFFFh is CS0 (bit 4). 800000h–BFFFFFh is CS2 (bit 5). C00000h–DFFFFFh is CS3 (bit 6). E00000h–EFFFFFh is CS4 (bit 7). F00000h and up is CS5 (bit 8). For the processor, the output address equals the input address.
- R2: The range FE0000h–FFFFFFh selects internal ROM (bit 3) while the remap bit is 0, and CS5 (bit 8) while it is 1.
- R3: A hardware reset (rst_n low) clears the remap bit, and remap_o reads 0.
- R4: A clock edge with cfg_we high and sw_rst low loads cfg_wdata into the remap bit, and remap_o shows the new value after that edge.
- R5: While sw_rst is high the remap bit keeps its value, and a write in the same cycle is ignored.
- R6: For bus-side masters (code 1 = USB, codes 4–7 = DMA engines 0–3), addresses 010000h–01FFFFh map to processor address minus 010000h. If the result is below 0000C0h, which is the register space, the access is refused.
- R7: For bus-side masters, addresses 090000h–0CFFFFh map to single-access RAM at processor address minus 080000h.
- R8: Bus-side masters are refused the ROM. They are also refused any address below 050000h that lies outside both windows.
- R9: Of the DMA engines only engine 3 (code 7) may reach external space (bits 4–8). Codes 4–6 are refused there. USB may reach external space. Bus-side addresses from 050000h up that lie outside the windows decode as in R1 and R2.
- R10: USB (code 1) is refused the dual-access RAM.
- R11: Master codes 2 and 3 are refused every access.
- R12: A refused request raises err_o, drives no select bit and drives addr_o to 0. An allowed request drives exactly one select bit with err_o low. With req_i low, every select bit and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the remap register |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset indication; holds the remap bit |
| cfg_we | input | 1 | Write strobe for the remap bit |
| cfg_wdata | input | 1 | Value written to the remap bit |
| remap_o | output | 1 | Current remap bit |
| req_i | input | 1 | Access request |
| master_i | input | 3 | Master code (0 CPU, 1 USB, 4–7 DMA 0–3) |
| addr_i | input | 24 | Byte address in the master's view |
| sel_o | output | 9 | One-hot region select |
| addr_o | output | 24 | Address in the processor view |
| err_o | output | 1 | Access refused |

## Verification
A wrong remap bit shows in the first cycle that an address in FE0000h–FFFFFFh is requested: ROM and CS5 swap. A wrong window offset shows at once as a shifted addr_o, or as a RAM select turning into an error. A permission slip shows at once as a select bit on a refused access, or as err_o on an allowed one. The bench therefore compares select, error and address on every random request against its own map. It also probes the remap bit after each write, software reset and hardware reset.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int ADDR_W   = 24;
  localparam int MASTER_W = 3;
  localparam int NUM_REG  = 9;
  localparam int REG_W    = $clog2(NUM_REG);
  localparam int NUM_WIN  = 2;

  typedef logic [ADDR_W-1:0]   addr_t;
  typedef logic [NUM_REG-1:0]  sel_t;
  typedef logic [REG_W-1:0]    reg_idx_t;
  typedef logic [MASTER_W-1:0] mst_t;

  // region indices (bit position in the select vector)
  localparam reg_idx_t RG_MMR   = REG_W'(0);
  localparam reg_idx_t RG_DARAM = REG_W'(1);
  localparam reg_idx_t RG_SARAM = REG_W'(2);
  localparam reg_idx_t RG_ROM   = REG_W'(3);
  localparam reg_idx_t RG_CS0   = REG_W'(4);
  localparam reg_idx_t RG_CS2   = REG_W'(5);
  localparam reg_idx_t RG_CS3   = REG_W'(6);
  localparam reg_idx_t RG_CS4   = REG_W'(7);
  localparam reg_idx_t RG_CS5   = REG_W'(8);

  // processor-view map boundaries (first byte of each region)
  localparam addr_t DARAM_BASE = 24'h0000C0;
  localparam addr_t SARAM_BASE = 24'h010000;
  localparam addr_t EXT_BASE   = 24'h050000;
  localparam addr_t CS2_BASE   = 24'h800000;
  localparam addr_t CS3_BASE   = 24'h C00000;
  localparam addr_t CS4_BASE   = 24'hE00000;
  localparam addr_t CS5_BASE   = 24'hF00000;
  localparam addr_t ROM_BASE   = 24'hFE0000;

  // bus-side windows: base, size, offset subtracted
  localparam addr_t WIN_LO  [NUM_WIN] = '{24'h010000, 24'h090000};
  localparam addr_t WIN_SZ  [NUM_WIN] = '{24'h010000, 24'h040000};
  localparam addr_t WIN_OFS [NUM_WIN] = '{24'h010000, 24'h080000};

  localparam mst_t M_CPU  = MASTER_W'(0);
  localparam mst_t M_USB  = MASTER_W'(1);
  localparam logic [1:0] DMA_EXT_ID = 2'd3;

  function automatic logic is_dma(input mst_t m);
    return m[MASTER_W-1];
  endfunction

  function automatic logic is_bus_side(input mst_t m);
    return (m == M_USB) || is_dma(m);
  endfunction

  function automatic logic is_unknown(input mst_t m);
    return !is_dma(m) && (m != M_CPU) && (m != M_USB);
  endfunction

  function automatic logic is_external(input reg_idx_t r);
    return r >= RG_CS0;
  endfunction

  // processor-view region lookup, upper regions compared first
  function automatic reg_idx_t region_of(input addr_t a, input logic remap);
    if (a >= ROM_BASE)        return remap ? RG_CS5 : RG_ROM;
    else if (a >= CS5_BASE)   return RG_CS5;
    else if (a >= CS4_BASE)   return RG_CS4;
    else if (a >= CS3_BASE)   return RG_CS3;
    else if (a >= CS2_BASE)   return RG_CS2;
    else if (a >= EXT_BASE)   return RG_CS0;
    else if (a >= SARAM_BASE) return RG_SARAM;
    else if (a >= DARAM_BASE) return RG_DARAM;
    else                      return RG_MMR;
  endfunction
endpackage

// File: rtl/sad_remap_reg.sv
module sad_remap_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic wr_en,
  input  logic wr_data,
  output logic wr_accept,
  output logic remap_q
);
  assign wr_accept = wr_en && !sw_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remap_q <= 1'b0;
    else if (wr_accept) remap_q <= wr_data;
  end
endmodule

// File: rtl/sad_addr_xlate.sv
module sad_addr_xlate
  import sad_pkg::*;
(
  input  addr_t             addr_in,
  input  logic              bus_side,
  output logic [NUM_WIN-1:0] win_hit,
  output logic              hole,
  output addr_t             cpu_addr
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_hit[w] = bus_side && (addr_in >= WIN_LO[w]) &&
                        (addr_in < WIN_LO[w] + WIN_SZ[w]);
  end

  always_comb begin
    cpu_addr = addr_in;
    for (int w = 0; w < NUM_WIN; w++)
      if (win_hit[w]) cpu_addr = addr_in - WIN_OFS[w];
  end

  assign hole = bus_side && !(|win_hit) && (addr_in < EXT_BASE);
endmodule

// File: rtl/sad_region_decode.sv
module sad_region_decode
  import sad_pkg::*;
(
  input  addr_t    cpu_addr,
  input  logic     remap,
  output reg_idx_t region,
  output sel_t     onehot
);
  assign region = region_of(cpu_addr, remap);

  for (genvar i = 0; i < NUM_REG; i++) begin : g_sel
    assign onehot[i] = (region == REG_W'(i));
  end
endmodule

// File: rtl/sad_access_check.sv
module sad_access_check
  import sad_pkg::*;
(
  input  mst_t     master,
  input  reg_idx_t region,
  input  logic     hole,
  output logic     deny
);
  always_comb begin
    deny = 1'b0;
    if (is_unknown(master))        deny = 1'b1;
    else if (is_bus_side(master)) begin
      if (hole)                    deny = 1'b1;
      else if (region == RG_MMR)   deny = 1'b1;
      else if (region == RG_ROM)   deny = 1'b1;
      else if (region == RG_DARAM) deny = (master == M_USB);
      else if (is_external(region))
        deny = is_dma(master) && (master[1:0] != DMA_EXT_ID);
    end
  end
endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
  import sad_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_rst,
  input  logic                cfg_we,
  input  logic                cfg_wdata,
  output logic                remap_o,
  input  logic                req_i,
  input  logic [MASTER_W-1:0] master_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REG-1:0]  sel_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                err_o
);
  logic                wr_accept;
  logic                remap_q;
  logic                bus_side;
  logic [NUM_WIN-1:0]  win_hit;
  logic                hole;
  addr_t               cpu_addr;
  reg_idx_t            region;
  sel_t                raw_sel;
  logic                deny;
  logic                grant;

  assign bus_side = is_bus_side(master_i);

  sad_remap_reg u_remap (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .wr_en(cfg_we), .wr_data(cfg_wdata),
    .wr_accept(wr_accept), .remap_q(remap_q)
  );

  sad_addr_xlate u_xlate (
    .addr_in(addr_i), .bus_side(bus_side),
    .win_hit(win_hit), .hole(hole), .cpu_addr(cpu_addr)
  );

  sad_region_decode u_dec (
    .cpu_addr(cpu_addr), .remap(remap_q),
    .region(region), .onehot(raw_sel)
  );

  sad_access_check u_chk_acc (
    .master(master_i), .region(region), .hole(hole), .deny(deny)
  );

  assign grant   = req_i && !deny;
  assign sel_o   = grant ? raw_sel : '0;
  assign addr_o  = grant ? cpu_addr : '0;
  assign err_o   = req_i && deny;
  assign remap_o = remap_q;
endmodule

// File: rtl/sad_checker.sv
module sad_checker
  import sad_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                sw_rst,
  input logic                cfg_we,
  input logic                cfg_wdata,
  input logic                remap_o,
  input logic                req_i,
  input logic [MASTER_W-1:0] master_i,
  input logic [NUM_REG-1:0]  sel_o,
  input logic                err_o,
  input logic                wr_accept,
  input logic [NUM_WIN-1:0]  win_hit
);
  // R4: accepted write lands on the next edge
  assert_write_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !sw_rst) |=> (remap_o == $past(cfg_wdata)));

  // R5: software reset holds the remap bit
  assert_swrst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> $stable(remap_o));

  // R5: no write accepted under software reset
  assert_swrst_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |-> !wr_accept);

  // R2: ROM only when not remapped and only for the processor
  assert_rom_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o[RG_ROM] |-> (!remap_o && master_i == M_CPU));

  // R9: DMA engines 0-2 never reach external space
  assert_ext_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i[MASTER_W-1] && master_i[1:0] != DMA_EXT_ID) |-> (sel_o[8:4] == '0));

  // R10: USB never selects dual-access RAM
  assert_usb_daram_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i == M_USB) |-> !sel_o[RG_DARAM]);

  // R11: unknown master codes always refused
  assert_unknown_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !master_i[MASTER_W-1] && master_i[MASTER_W-2:0] > 2'd1) |-> err_o);

  // R12: exactly one select on an allowed request, none on refusal or idle
  assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !err_o) |-> ($countones(sel_o) == 1));
  assert_err_nosel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (sel_o == '0));
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> (sel_o == '0 && !err_o));

  // R6/R7: the two windows never overlap
  assert_win_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_hit));
endmodule

bind sys_addr_decoder sad_checker u_sad_checker (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .remap_o(remap_o), .req_i(req_i),
  .master_i(master_i), .sel_o(sel_o), .err_o(err_o),
  .wr_accept(wr_accept), .win_hit(win_hit)
);

// File: tb/sys_addr_decoder_tb.sv
module sys_addr_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_wdata = 1'b0;
  logic        remap_o;
  logic        req_i = 1'b0;
  logic [2:0]  master_i = 3'd0;
  logic [23:0] addr_i = 24'd0;
  logic [8:0]  sel_o;
  logic [23:0] addr_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  logic model_remap = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  sys_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .remap_o(remap_o), .req_i(req_i),
    .master_i(master_i), .addr_i(addr_i), .sel_o(sel_o),
    .addr_o(addr_o), .err_o(err_o)
  );

  // reference map, written as table lookups on the processor address
  function automatic int ref_bit(input logic [23:0] a, input logic rm);
    int b;
    b = 0;
    if (a >= 24'h0000C0) b = 1;
    if (a >= 24'h010000) b = 2;
    if (a >= 24'h050000) b = 4;
    if (a >= 24'h800000) b = 5;
    if (a >= 24'hC00000) b = 6;
    if (a >= 24'hE00000) b = 7;
    if (a >= 24'hF00000) b = 8;
    if (a >= 24'hFE0000 && !rm) b = 3;
    return b;
  endfunction

  task automatic ref_access(input logic [23:0] a, input logic [2:0] m,
                            input logic rm, output logic [8:0] s,
                            output logic [23:0] pa, output logic e);
    int b;
    logic bus, ok;
    bus = (m == 3'd1) || (m >= 3'd4);
    pa = a;
    ok = 1'b1;
    if (m == 3'd2 || m == 3'd3) ok = 1'b0;
    if (bus) begin
      if (a >= 24'h010000 && a <= 24'h01FFFF)      pa = a - 24'h010000;
      else if (a >= 24'h090000 && a <= 24'h0CFFFF) pa = a - 24'h080000;
      else if (a < 24'h050000) ok = 1'b0;
    end
    b = ref_bit(pa, rm);
    if (bus) begin
      if (b == 0 || b == 3) ok = 1'b0;
      if (b == 1 && m == 3'd1) ok = 1'b0;
      if (b >= 4 && m >= 3'd4 && m != 3'd7) ok = 1'b0;
    end
    e  = ok ? 1'b0 : 1'b1;
    s  = ok ? (9'd1 << b) : 9'd0;
    if (!ok) pa = 24'd0;
  endtask

  task automatic check_access(input logic [23:0] a, input logic [2:0] m, input string tag);
    logic [8:0] es; logic [23:0] ea; logic ee;
    @(negedge clk);
    req_i = 1'b1; master_i = m; addr_i = a;
    #3;
    ref_access(a, m, model_remap, es, ea, ee);
    checks++;
    if (sel_o !== es || addr_o !== ea || err_o !== ee) begin
      errors++;
      $display("FAIL %s addr=%h m=%0d: sel=%b addr=%h err=%b expected sel=%b addr=%h err=%b",
               tag, a, m, sel_o, addr_o, err_o, es, ea, ee);
    end
  endtask

  task automatic check_remap(input logic exp, input string tag);
    checks++;
    if (remap_o !== exp) begin
      errors++;
      $display("FAIL %s remap=%b expected %b", tag, remap_o, exp);
    end
  endtask

  task automatic write_remap(input logic v, input logic swr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v; sw_rst = swr;
    @(negedge clk);
    cfg_we = 1'b0; sw_rst = 1'b0;
    if (!swr) model_remap = v;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state
    check_remap(1'b0, "R3 reset value");
    checks++;
    if (sel_o !== 9'd0 || err_o !== 1'b0) begin
      errors++;
      $display("FAIL R12 idle sel=%b err=%b expected 0 0", sel_o, err_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: CPU boundaries
    check_access(24'h0000BF, 3'd0, "R1 mmr top");
    check_access(24'h0000C0, 3'd0, "R1 daram base");
    check_access(24'h00FFFF, 3'd0, "R1 daram top");
    check_access(24'h010000, 3'd0, "R1 saram base");
    check_access(24'h04FFFF, 3'd0, "R1 saram top");
    check_access(24'h050000, 3'd0, "R1 cs0 base");
    check_access(24'h7FFFFF, 3'd0, "R1 cs0 top");
    check_access(24'h800000, 3'd0, "R1 cs2 base");
    check_access(24'hC00000, 3'd0, "R1 cs3 base");
    check_access(24'hE00000, 3'd0, "R1 cs4 base");
    check_access(24'hF00000, 3'd0, "R1 cs5 base");
    // R2: ROM vs CS5
    check_access(24'hFDFFFF, 3'd0, "R2 cs5 below rom");
    check_access(24'hFE0000, 3'd0, "R2 rom base");
    check_access(24'hFFFFFF, 3'd0, "R2 rom top");
    // R4: write loads the bit
    write_remap(1'b1, 1'b0);
    check_remap(1'b1, "R4 write one");
    check_access(24'hFE0000, 3'd0, "R2 remapped cs5");
    check_access(24'hFFFFFF, 3'd7, "R9 dma3 remapped top");
    // R5: software reset holds and blocks write
    write_remap(1'b0, 1'b1);
    check_remap(1'b1, "R5 sw reset hold");
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    check_remap(1'b1, "R5 sw reset alone");
    // R3: hardware reset clears
    @(negedge clk); rst_n = 1'b0;
    #3; model_remap = 1'b0;
    check_remap(1'b0, "R3 hw reset clears");
    @(negedge clk); rst_n = 1'b1;
    check_access(24'hFE0000, 3'd0, "R3 rom back after reset");

    // R6/R7 windows
    check_access(24'h010000, 3'd4, "R6 window maps to mmr");
    check_access(24'h0100BF, 3'd5, "R6 window mmr top");
    check_access(24'h0100C0, 3'd5, "R6 window daram base");
    check_access(24'h01FFFF, 3'd6, "R6 window daram top");
    check_access(24'h090000, 3'd4, "R7 window saram base");
    check_access(24'h0CFFFF, 3'd1, "R7 window saram top usb");
    // R8
    check_access(24'h000100, 3'd7, "R8 hole low");
    check_access(24'h020000, 3'd1, "R8 hole mid");
    check_access(24'hFE0000, 3'd7, "R8 dma rom refused");
    check_access(24'hFF0000, 3'd1, "R8 usb rom refused");
    // R9
    check_access(24'h050000, 3'd7, "R9 dma3 cs0");
    check_access(24'h0D0000, 3'd7, "R9 dma3 above window");
    check_access(24'h800000, 3'd4, "R9 dma0 ext refused");
    check_access(24'hE00000, 3'd6, "R9 dma2 ext refused");
    check_access(24'hC00000, 3'd1, "R9 usb ext");
    // R10
    check_access(24'h010200, 3'd1, "R10 usb daram refused");
    // R11
    check_access(24'h0000C0, 3'd2, "R11 code2");
    check_access(24'h800000, 3'd3, "R11 code3");

    // R12 idle after activity
    @(negedge clk); req_i = 1'b0; master_i = 3'd2; addr_i = 24'hFFFFFF;
    #3; checks++;
    if (sel_o !== 9'd0 || err_o !== 1'b0) begin
      errors++;
      $display("FAIL R12 idle sel=%b err=%b expected 0 0", sel_o, err_o);
    end

    // random mix with remap toggling
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5AD0_1234);
    end
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] a;
      logic [2:0]  m;
      int pick;
      pick = $urandom_range(0, 3);
      a = 24'($urandom);
      if (pick == 1) a = {8'h00, a[15:0]} + 24'($urandom_range(0, 4)) * 24'h010000;
      if (pick == 2) a = 24'hFC0000 | {8'h00, a[17:0]};
      m = 3'($urandom_range(0, 7));
      if (i % 97 == 0) write_remap(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      check_access(a, m, "R12 random decode");
    end
    check_remap(model_remap, "R4 final remap");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule